// File: doc/BRIEF.md
# Dual-Mode Internal Data Memory Decoder

This block sits between a small 8-bit processor core and its on-chip data storage. Every data access arrives as a resolved 8-bit address plus an access-mode code. The block decides whether the access goes to a 256-byte internal RAM, which is modelled inside the block, or out to a special-function-register (SFR) bus. The SFR contents live outside the block.

The top half of the address range is shared by two targets. A direct access with address bit 7 set reaches an SFR. An indirect access or a stack access to the same address reaches the hidden upper half of the RAM. The lower half always reaches RAM. The stack may therefore use any of the 256 bytes. No path in this block leads to any memory other than the internal RAM or the SFR bus.

RAM writes take effect on the clock edge. Reads have one cycle of latency. The read data is held until the next read.

Top module: `idata_router`

## Requirements
- R1: Any access with address 0x00–0x7F reaches internal RAM in every mode, and `sfr_sel` stays low.
- R2: A direct access (`req_mode` = 2'b00) with address 0x80–0xFF raises `sfr_sel` in the same cycle. It presents the address on `sfr_addr` and the write data on `sfr_wdata`. `sfr_we` is raised only when the access is a write.
- R3: An indirect access (`req_mode` = 2'b01) to 0x80–0xFF reaches the upper 128 RAM bytes, and `sfr_sel` stays low.
- R4: A stack access (`req_mode` = 2'b10) is routed exactly like an indirect access, so stack data can sit at 0x80–0xFF. Code 2'b11 is also treated as indirect.
- R5: While `sfr_sel` is high, internal RAM is not written. A direct write to 0x80–0xFF leaves the upper RAM byte at that address unchanged.
- R6: Read data appears on `rsp_rdata` on the first clock edge after the read request, and holds until the next read.
- R7: The returned byte is chosen by the route decided in the request cycle. For an SFR read, it is the value on `sfr_rdata` during that cycle, and later changes on `sfr_rdata` do not alter it.
- R8: A synchronous active-high `rst` clears `rsp_rdata` to 0x00 and does not clear RAM contents.
- R9: With neither strobe high, `sfr_sel` and `sfr_we` stay low and no RAM byte changes.
- R10: A read and a write to the same RAM byte in one cycle return the old byte. The new byte is visible to the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | 8 | Resolved data address |
| req_mode | input | 2 | 00 direct, 01 indirect, 10 stack, 11 treated as indirect |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Registered read data |
| sfr_sel | output | 1 | SFR access select |
| sfr_we | output | 1 | SFR write enable |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, sampled in the request cycle |

## Verification
The bench uses the same upper address, for example 0xA0 or 0x90, in all three modes.
- If a decoder ignored the mode, an indirect read would return the SFR value instead of the stored byte.
- If a decoder forgot to block RAM writes during SFR writes, it would corrupt the hidden upper byte.

The bench changes `sfr_rdata` after an SFR read. A design that muxed the live SFR value at the output, rather than the captured one, would then show a changing response.

Other corner cases:
- A read and a write to the same byte in one cycle: a write-first RAM would return the new byte there.
- A reset in the middle of a run: a design that cleared storage on reset would lose earlier data.

// File: rtl/idr_pkg.sv
package idr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'b00,
    ACC_INDIRECT = 2'b01,
    ACC_STACK    = 2'b10,
    ACC_RSVD     = 2'b11
  } acc_mode_e;

  // Only a direct access into the upper half targets the SFR space.
  function automatic logic goes_to_sfr(input acc_mode_e mode, input logic upper);
    return (mode == ACC_DIRECT) && upper;
  endfunction
endpackage

// File: rtl/idr_decode.sv
module idr_decode
  import idr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    mode,
  input  logic          rd,
  input  logic          wr,
  output logic          sfr_hit,
  output logic          sfr_wr,
  output logic          ram_we,
  output logic          ram_re
);
  localparam int MSB = AW - 1;

  logic access;
  logic sfr_target;

  assign access     = rd | wr;
  assign sfr_target = goes_to_sfr(acc_mode_e'(mode), addr[MSB]);
  assign sfr_hit    = access & sfr_target;
  assign sfr_wr     = wr & sfr_target;
  assign ram_we     = wr & ~sfr_target;
  assign ram_re     = rd & ~sfr_target;

  assert_lower_to_ram_R1: assert property (@(posedge clk) disable iff (rst)
    (access && !addr[MSB]) |-> (!sfr_hit && (ram_we || ram_re)));

  assert_nondirect_to_ram_R3: assert property (@(posedge clk) disable iff (rst)
    (access && mode != 2'b00) |-> !sfr_hit);

  assert_sfr_blocks_ram_R5: assert property (@(posedge clk) disable iff (rst)
    sfr_hit |-> !ram_we);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !access |-> (!sfr_hit && !ram_we && !sfr_wr));
endmodule

// File: rtl/idr_ram.sv
module idr_ram
  import idr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic          re,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Read-first: a same-cycle write is not visible in q.
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[addr];
  end
endmodule

// File: rtl/idr_rsp.sv
module idr_rsp
  import idr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          sfr_hit,
  input  logic [DW-1:0] sfr_rdata,
  input  logic [DW-1:0] ram_q,
  output logic [DW-1:0] rdata
);
  logic          route_sfr_q;
  logic [DW-1:0] sfr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      route_sfr_q <= 1'b0;
      sfr_q       <= '0;
    end else if (rd) begin
      route_sfr_q <= sfr_hit;
      if (sfr_hit) sfr_q <= sfr_rdata;
    end
  end

  assign rdata = route_sfr_q ? sfr_q : ram_q;
endmodule

// File: rtl/idata_router.sv
module idata_router
  import idr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_mode,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          sfr_sel,
  output logic          sfr_we,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata
);
  logic          hit_sfr;
  logic          hit_sfr_wr;
  logic          ram_we;
  logic          ram_re;
  logic [DW-1:0] ram_q;

  idr_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst(rst), .addr(req_addr), .mode(req_mode),
    .rd(req_rd), .wr(req_wr),
    .sfr_hit(hit_sfr), .sfr_wr(hit_sfr_wr), .ram_we(ram_we), .ram_re(ram_re)
  );

  idr_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .rst(rst), .addr(req_addr), .we(ram_we), .re(ram_re),
    .wdata(req_wdata), .q(ram_q)
  );

  idr_rsp #(.DW(DW)) u_rsp (
    .clk(clk), .rst(rst), .rd(req_rd), .sfr_hit(hit_sfr),
    .sfr_rdata(sfr_rdata), .ram_q(ram_q), .rdata(rsp_rdata)
  );

  assign sfr_sel   = hit_sfr;
  assign sfr_we    = hit_sfr_wr;
  assign sfr_addr  = req_addr;
  assign sfr_wdata = req_wdata;

  // Assertion helper: high once a cycle has passed since reset.
  logic since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 1'b0;
    else     since_rst <= 1'b1;
  end

  assert_sfr_upper_direct_R2: assert property (@(posedge clk) disable iff (rst)
    sfr_sel |-> (req_addr[AW-1] && req_mode == 2'b00));

  assert_sfr_we_needs_sel_R2: assert property (@(posedge clk) disable iff (rst)
    sfr_we |-> (sfr_sel && req_wr));

  assert_stack_not_sfr_R4: assert property (@(posedge clk) disable iff (rst)
    (req_mode == 2'b10) |-> !sfr_sel);

  assert_rdata_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst && !req_rd) |=> $stable(rsp_rdata));

  assert_sfr_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst && sfr_sel && req_rd) |=> (rsp_rdata == $past(sfr_rdata)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (rsp_rdata == '0));
endmodule

// File: tb/sim_idata_router.sv
module sim_idata_router;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_addr;
  logic [1:0] req_mode;
  logic       req_rd;
  logic       req_wr;
  logic [7:0] req_wdata;
  logic [7:0] rsp_rdata;
  logic       sfr_sel;
  logic       sfr_we;
  logic [7:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;
  logic [7:0] sfr_xor = 8'h5A;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [1:0] DIR = 2'b00, IND = 2'b01, STK = 2'b10, RSV = 2'b11;

  always #5 clk = ~clk;

  // External SFR model: read value is a function of the presented address.
  assign sfr_rdata = sfr_addr ^ sfr_xor;

  idata_router u0 (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_mode(req_mode),
    .req_rd(req_rd), .req_wr(req_wr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .sfr_sel(sfr_sel), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_rd = 0; req_wr = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] m, input logic [7:0] d);
    @(negedge clk);
    req_addr = a; req_mode = m; req_wdata = d; req_rd = 0; req_wr = 1;
    @(posedge clk);
    @(negedge clk);
    req_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] m, output logic [7:0] d);
    @(negedge clk);
    req_addr = a; req_mode = m; req_rd = 1; req_wr = 0;
    @(posedge clk);
    #1 d = rsp_rdata;
    @(negedge clk);
    req_rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R8", "rdata after reset", rsp_rdata, 8'h00);
    @(negedge clk);
    req_addr = 8'hA0; req_mode = DIR;
    #1;
    chk("R9", "sfr_sel idle", {7'b0, sfr_sel}, 8'h00);
    chk("R9", "sfr_we idle", {7'b0, sfr_we}, 8'h00);
    rd(8'h33, IND, v);
    v = v;
  endtask

  task automatic t_lower();
    logic [7:0] v;
    wr(8'h25, DIR, 8'hA1);
    rd(8'h25, IND, v);
    chk("R1", "direct write, indirect read 0x25", v, 8'hA1);
    wr(8'h7F, STK, 8'h3B);
    @(negedge clk);
    req_addr = 8'h7F; req_mode = DIR; req_rd = 1;
    #1 chk("R1", "sfr_sel on lower read", {7'b0, sfr_sel}, 8'h00);
    @(posedge clk);
    #1 chk("R1", "stack write, direct read 0x7F", rsp_rdata, 8'h3B);
    idle();
  endtask

  task automatic t_direct_upper();
    logic [7:0] v;
    @(negedge clk);
    req_addr = 8'hA0; req_mode = DIR; req_wdata = 8'h3C; req_wr = 1;
    #1;
    chk("R2", "sfr_sel on direct write", {7'b0, sfr_sel}, 8'h01);
    chk("R2", "sfr_we on direct write", {7'b0, sfr_we}, 8'h01);
    chk("R2", "sfr_addr", sfr_addr, 8'hA0);
    chk("R2", "sfr_wdata", sfr_wdata, 8'h3C);
    @(posedge clk);
    @(negedge clk);
    req_wr = 0; req_rd = 1;
    #1 chk("R2", "sfr_we low on read", {7'b0, sfr_we}, 8'h00);
    @(posedge clk);
    #1 v = rsp_rdata;
    chk("R2", "direct read returns SFR", v, 8'hA0 ^ 8'h5A);
    idle();
  endtask

  task automatic t_indirect_upper();
    logic [7:0] v;
    @(negedge clk);
    req_addr = 8'hA0; req_mode = IND; req_wdata = 8'h77; req_wr = 1;
    #1 chk("R3", "sfr_sel on indirect write", {7'b0, sfr_sel}, 8'h00);
    @(posedge clk);
    idle();
    rd(8'hA0, IND, v);
    chk("R3", "indirect read upper RAM 0xA0", v, 8'h77);
  endtask

  task automatic t_stack();
    logic [7:0] v;
    wr(8'hFF, STK, 8'hE1);
    rd(8'hFF, IND, v);
    chk("R4", "stack write, indirect read 0xFF", v, 8'hE1);
    wr(8'hC4, IND, 8'h4D);
    rd(8'hC4, STK, v);
    chk("R4", "indirect write, stack read 0xC4", v, 8'h4D);
    rd(8'hFF, RSV, v);
    chk("R4", "code 11 read 0xFF as indirect", v, 8'hE1);
  endtask

  task automatic t_shadow();
    logic [7:0] v;
    wr(8'h90, IND, 8'h11);
    wr(8'h90, DIR, 8'h99);
    rd(8'h90, IND, v);
    chk("R5", "upper RAM untouched by SFR write", v, 8'h11);
  endtask

  task automatic t_latency_hold();
    logic [7:0] v;
    wr(8'h50, IND, 8'hC6);
    rd(8'h25, IND, v);
    @(negedge clk);
    req_addr = 8'h50; req_mode = IND; req_rd = 1;
    #1 chk("R6", "old data before edge", rsp_rdata, 8'hA1);
    @(posedge clk);
    #1 chk("R6", "new data after one edge", rsp_rdata, 8'hC6);
    @(negedge clk);
    req_rd = 0; req_addr = 8'h25;
    repeat (3) @(posedge clk);
    #1 chk("R6", "data held while idle", rsp_rdata, 8'hC6);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    rd(8'hB3, DIR, v);
    chk("R7", "SFR read value", v, 8'hB3 ^ 8'h5A);
    @(negedge clk);
    sfr_xor = 8'hFF; req_addr = 8'hB3; req_mode = DIR;
    repeat (2) @(posedge clk);
    #1 chk("R7", "captured SFR byte unchanged", rsp_rdata, 8'hB3 ^ 8'h5A);
    @(negedge clk);
    sfr_xor = 8'h5A;
    rd(8'h50, IND, v);
    chk("R7", "RAM route after SFR read", v, 8'hC6);
  endtask

  task automatic t_rfw();
    logic [7:0] v;
    wr(8'h40, IND, 8'h12);
    @(negedge clk);
    req_addr = 8'h40; req_mode = IND; req_wdata = 8'h34; req_rd = 1; req_wr = 1;
    @(posedge clk);
    #1 chk("R10", "same-cycle read sees old", rsp_rdata, 8'h12);
    idle();
    rd(8'h40, IND, v);
    chk("R10", "next read sees new", v, 8'h34);
  endtask

  task automatic t_reset_keep();
    logic [7:0] v;
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    #1 chk("R8", "rdata cleared by mid-run reset", rsp_rdata, 8'h00);
    @(negedge clk);
    rst = 0;
    rd(8'h25, IND, v);
    chk("R8", "RAM kept over reset 0x25", v, 8'hA1);
    rd(8'hA0, IND, v);
    chk("R8", "RAM kept over reset 0xA0", v, 8'h77);
  endtask

  task automatic t_idle_nowrite();
    logic [7:0] v;
    @(negedge clk);
    req_addr = 8'h25; req_mode = IND; req_wdata = 8'hEE; req_rd = 0; req_wr = 0;
    repeat (2) @(posedge clk);
    rd(8'h25, IND, v);
    chk("R9", "no write without strobe", v, 8'hA1);
  endtask

  initial begin
    rst = 1; req_addr = 0; req_mode = DIR; req_rd = 0; req_wr = 0; req_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 0;
    t_lower();
    t_direct_upper();
    t_indirect_upper();
    t_stack();
    t_shadow();
    t_latency_hold();
    t_capture();
    t_rfw();
    t_idle_nowrite();
    t_reset_keep();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule